// File: doc/BRIEF.md
# Per-Channel Hit Output Former

This block forms the single logic output of one readout channel. It takes two level signals from the analog front end, modelled here as digital inputs: the discriminator level and a pulse whose width encodes the measured charge. Both inputs cross into the system clock domain through synchronizer chains. A global select picks one of two output styles. In time-over-threshold style the synchronized discriminator level goes straight to the output. In charge style, a rising edge of the charge pulse starts an output pulse as wide as the input pulse, and a programmable dead window follows it.

A 2-bit per-channel override sits on top of both styles. It can pass the formed signal, hold the output high, hold it low for board connectivity checks, or silence the channel. The dead window is counted in clock cycles. The parameter `STEP_CYC` sets the number of cycles in one 100 ns step, and the window lasts `(3 + code)` steps. With a 3-bit code the window therefore spans 300 ns to 1000 ns, and code 5 gives the nominal 800 ns.

Top module: `hit_out_former`

## Requirements
- R1: When `chan_mode` is 2'b01 (forced high), `out_bit` is 1 from the clock edge after the mode is applied, whatever the analog inputs do.
- R2: When `chan_mode` is 2'b10 (forced low), `out_bit` is 0 from the clock edge after the mode is applied, whatever the analog inputs do.
- R3: When `chan_mode` is 2'b11 (off), `out_bit` is held at 0.
- R4: When `chan_mode` is 2'b00 (active) and `tot_sel` is 1, `out_bit` follows `disc_in` three clock edges late, and every discriminator pulse is passed on, including repeated pulses.
- R5: When `chan_mode` is 2'b00 and `tot_sel` is 0 (charge style), a rising edge on `qpulse_in` raises `out_bit` four clock edges later, and the output pulse is as many cycles wide as the input pulse.
- R6: In charge style, a new rising edge on `qpulse_in` is ignored during the dead window. The window starts when the output pulse ends and lasts `(3 + dead_code) * STEP_CYC` cycles.
- R7: In charge style, a charge input that rises during the dead window and stays high after the window ends produces no output pulse. Only a fresh rising edge starts a pulse.
- R8: Leaving active charge style clears any running pulse or dead window. A mode change made while a pulse is running takes effect at the next clock edge.
- R9: During reset `out_bit` is 0. After reset, with both inputs low, it stays 0.
- R10: The dead window length scales with the code. This holds at both ends of the range: code 0 gives 3 steps and code 7 gives 10 steps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| disc_in | input | 1 | Discriminator level from the front end (asynchronous) |
| qpulse_in | input | 1 | Charge-encoded pulse from the front end (asynchronous) |
| tot_sel | input | 1 | Output style: 0 charge, 1 time-over-threshold |
| chan_mode | input | 2 | Channel override: 00 active, 01 high, 10 low, 11 off |
| dead_code | input | DEAD_W | Dead window code, length (3 + code) steps |
| out_bit | output | 1 | Channel output |

## Verification
The bench builds the block with `STEP_CYC` = 2. This keeps the longest dead window at 20 cycles, so both ends of the code range can be timed exactly against the cycle at which a second hit is or is not accepted. `SYNC_STAGES` keeps its default of 2, which fixes the edge-to-output latencies at three cycles for time-over-threshold style and four cycles for charge style. The bench probes the dead window one cycle before it closes and in the first cycle after it closes.

// File: rtl/hit_out_pkg.sv
package hit_out_pkg;

   typedef enum logic [1:0] {
      OVR_PASS = 2'b00,
      OVR_HIGH = 2'b01,
      OVR_LOW  = 2'b10,
      OVR_MUTE = 2'b11
   } ovr_mode_t;

   typedef enum logic [1:0] {
      QS_IDLE  = 2'b00,
      QS_PULSE = 2'b01,
      QS_DEAD  = 2'b10
   } qstate_t;

endpackage

// File: rtl/hit_sync.sv
module hit_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("hit_sync: STAGES must be at least 2");
   end

   for (genvar i = 0; i < STAGES; i++) begin : g_st
      logic r;
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) r <= 1'b0;
            else        r <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) r <= 1'b0;
            else        r <= g_st[i-1].r;
         end
      end
   end

   assign q = g_st[STAGES-1].r;

endmodule

// File: rtl/charge_shaper.sv
module charge_shaper
   import hit_out_pkg::*;
#(
   parameter int STEP_CYC  = 25,
   parameter int DEAD_W    = 3,
   parameter int MIN_STEPS = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              q_sync,
   input  logic [DEAD_W-1:0] dead_code,
   output logic              charge_lvl
);

   localparam int MAX_STEPS = MIN_STEPS + (1 << DEAD_W) - 1;
   localparam int MAX_WIN   = MAX_STEPS * STEP_CYC;
   localparam int CNT_W     = $clog2(MAX_WIN + 1);

   if (STEP_CYC < 1) begin : g_bad_step
      $error("charge_shaper: STEP_CYC must be positive");
   end
   if (DEAD_W < 1) begin : g_bad_w
      $error("charge_shaper: DEAD_W must be positive");
   end

   qstate_t          st;
   logic             q_prev;
   logic             rise;
   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] win_len;

   assign rise    = q_sync & ~q_prev;
   assign win_len = CNT_W'((MIN_STEPS + int'(dead_code)) * STEP_CYC);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q_prev <= 1'b0;
      else        q_prev <= q_sync;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st  <= QS_IDLE;
         cnt <= '0;
      end else if (!en) begin
         st  <= QS_IDLE;
         cnt <= '0;
      end else begin
         unique case (st)
            QS_IDLE: if (rise) st <= QS_PULSE;
            QS_PULSE: if (!q_sync) begin
               st  <= QS_DEAD;
               cnt <= win_len - CNT_W'(1);
            end
            QS_DEAD: begin
               if (cnt == '0) st  <= QS_IDLE;
               else           cnt <= cnt - CNT_W'(1);
            end
            default: st <= QS_IDLE;
         endcase
      end
   end

   assign charge_lvl = (st == QS_PULSE);

   // R6: a dead window never turns straight into a new pulse
   p_no_hit_in_dead_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (en && st == QS_DEAD) |=> (st != QS_PULSE));

   // R8: leaving active charge style clears pulse and window
   p_clear_on_exit_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (st == QS_IDLE && cnt == '0));

   // R10: the window counter stays below the longest programmable window
   p_dead_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (st == QS_DEAD) |-> (int'(cnt) < MAX_WIN));

   // R5: a pulse ends only once the synchronized charge input has dropped
   p_pulse_tracks_input_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (en && st == QS_PULSE && q_sync) |=> (st == QS_PULSE));

endmodule

// File: rtl/out_select.sv
module out_select
   import hit_out_pkg::*;
(
   input  logic       tot_sel,
   input  logic [1:0] chan_mode,
   input  logic       disc_sync,
   input  logic       charge_lvl,
   output logic       out_d
);

   ovr_mode_t ovr;
   logic      formed;

   assign ovr    = ovr_mode_t'(chan_mode);
   assign formed = tot_sel ? disc_sync : charge_lvl;

   always_comb begin
      unique case (ovr)
         OVR_PASS: out_d = formed;
         OVR_HIGH: out_d = 1'b1;
         OVR_LOW:  out_d = 1'b0;
         OVR_MUTE: out_d = 1'b0;
         default:  out_d = 1'b0;
      endcase
   end

endmodule

// File: rtl/hit_out_former.sv
module hit_out_former
   import hit_out_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int STEP_CYC    = 25,
   parameter int DEAD_W      = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              disc_in,
   input  logic              qpulse_in,
   input  logic              tot_sel,
   input  logic [1:0]        chan_mode,
   input  logic [DEAD_W-1:0] dead_code,
   output logic              out_bit
);

   localparam int MIN_STEPS = 3;

   logic disc_s;
   logic q_s;
   logic charge_en;
   logic charge_lvl;
   logic out_d;

   hit_sync #(.STAGES(SYNC_STAGES)) u_sync_disc (
      .clk(clk), .rst_n(rst_n), .d(disc_in), .q(disc_s)
   );

   hit_sync #(.STAGES(SYNC_STAGES)) u_sync_q (
      .clk(clk), .rst_n(rst_n), .d(qpulse_in), .q(q_s)
   );

   assign charge_en = (chan_mode == OVR_PASS) && !tot_sel;

   charge_shaper #(
      .STEP_CYC(STEP_CYC), .DEAD_W(DEAD_W), .MIN_STEPS(MIN_STEPS)
   ) u_shaper (
      .clk(clk), .rst_n(rst_n), .en(charge_en), .q_sync(q_s),
      .dead_code(dead_code), .charge_lvl(charge_lvl)
   );

   out_select u_sel (
      .tot_sel(tot_sel), .chan_mode(chan_mode), .disc_sync(disc_s),
      .charge_lvl(charge_lvl), .out_d(out_d)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) out_bit <= 1'b0;
      else        out_bit <= out_d;
   end

   p_force_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (chan_mode == 2'b01) |=> out_bit);

   p_force_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (chan_mode == 2'b10) |=> !out_bit);

   p_mute_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (chan_mode == 2'b11) |=> !out_bit);

   p_tot_follow_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (chan_mode == 2'b00 && tot_sel) |=> (out_bit == $past(disc_s)));

endmodule

// File: tb/tb_hit_out_former.sv
module tb_hit_out_former;

   localparam int STEP = 2;
   localparam int DW   = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          disc_in = 1'b0;
   logic          qpulse_in = 1'b0;
   logic          tot_sel = 1'b0;
   logic [1:0]    chan_mode = 2'b00;
   logic [DW-1:0] dead_code = '0;
   logic          out_bit;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   hit_out_former #(.SYNC_STAGES(2), .STEP_CYC(STEP), .DEAD_W(DW)) dut (
      .clk(clk), .rst_n(rst_n), .disc_in(disc_in), .qpulse_in(qpulse_in),
      .tot_sel(tot_sel), .chan_mode(chan_mode), .dead_code(dead_code),
      .out_bit(out_bit)
   );

   // {tot_sel, chan_mode[1:0], disc_in, qpulse_in, expected out}
   localparam logic [5:0] VEC [8] = '{
      6'b0_01_0_0_1, 6'b0_01_1_1_1, 6'b0_10_1_1_0, 6'b0_11_1_1_0,
      6'b1_00_1_0_1, 6'b1_00_0_1_0, 6'b1_01_0_0_1, 6'b1_10_1_1_0
   };
   localparam int VREQ [8] = '{1, 1, 2, 3, 4, 4, 1, 2};

   task automatic check(input string req, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
      end
   endtask

   task automatic check_int(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic tick(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic go_idle();
      qpulse_in = 1'b0;
      disc_in   = 1'b0;
      tot_sel   = 1'b0;
      chan_mode = 2'b00;
      tick(60);
   endtask

   // First pulse: rise at step 0, fall at step 5. Second rise at step k,
   // lasting 3 steps. The result is the output at step k+4.
   task automatic second_hit(input logic [DW-1:0] code, input int k, output logic seen);
      dead_code = code;
      go_idle();
      qpulse_in = 1'b1;
      seen = 1'b0;
      for (int i = 1; i <= k + 6; i++) begin
         @(negedge clk);
         if (i == k + 4) seen = out_bit;
         if (i == 5)     qpulse_in = 1'b0;
         if (i == k)     qpulse_in = 1'b1;
         if (i == k + 3) qpulse_in = 1'b0;
      end
   endtask

   initial begin : watchdog
      #400000;
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin : main
      logic seen;
      int   highs;
      int   first;

      // R9: reset state
      tick(3);
      check("R9 out during reset", out_bit, 1'b0);
      rst_n = 1'b1;
      tick(10);
      check("R9 out idle after reset", out_bit, 1'b0);

      // vector table for the static overrides and time-over-threshold style
      for (int v = 0; v < 8; v++) begin
         tot_sel   = VEC[v][5];
         chan_mode = VEC[v][4:3];
         disc_in   = VEC[v][2];
         qpulse_in = VEC[v][1];
         tick(6);
         check($sformatf("R%0d vector %0d", VREQ[v], v), out_bit, VEC[v][0]);
      end

      // R4: latency of three edges and repeated pulses
      go_idle();
      tot_sel = 1'b1;
      tick(4);
      disc_in = 1'b1;
      highs = 0;
      first = -1;
      for (int i = 1; i <= 12; i++) begin
         @(negedge clk);
         if (out_bit) begin
            highs++;
            if (first < 0) first = i;
         end
         if (i == 2) disc_in = 1'b0;
         if (i == 4) disc_in = 1'b1;
         if (i == 6) disc_in = 1'b0;
      end
      check_int("R4 tot first high step", first, 3);
      check_int("R4 tot high cycles (two pulses)", highs, 4);

      // R5: charge pulse latency and width
      dead_code = 3'd0;
      go_idle();
      qpulse_in = 1'b1;
      highs = 0;
      first = -1;
      for (int i = 1; i <= 15; i++) begin
         @(negedge clk);
         if (out_bit) begin
            highs++;
            if (first < 0) first = i;
         end
         if (i == 5) qpulse_in = 1'b0;
      end
      check_int("R5 charge first high step", first, 4);
      check_int("R5 charge pulse width", highs, 5);

      // R6 / R10: dead window edges for code 0 (6 cycles) and code 7 (20 cycles)
      second_hit(3'd0, 11, seen);
      check("R6 hit one cycle before window end ignored (code 0)", seen, 1'b0);
      second_hit(3'd0, 12, seen);
      check("R10 hit at window end accepted (code 0)", seen, 1'b1);
      second_hit(3'd7, 25, seen);
      check("R10 hit one cycle before window end ignored (code 7)", seen, 1'b0);
      second_hit(3'd7, 26, seen);
      check("R10 hit at window end accepted (code 7)", seen, 1'b1);

      // R7: input rising in the window and held high gives no second pulse
      dead_code = 3'd0;
      go_idle();
      qpulse_in = 1'b1;
      highs = 0;
      for (int i = 1; i <= 30; i++) begin
         @(negedge clk);
         if (out_bit) highs++;
         if (i == 5) qpulse_in = 1'b0;
         if (i == 7) qpulse_in = 1'b1;
      end
      check_int("R7 held input gives one pulse only", highs, 5);
      qpulse_in = 1'b0;

      // R8: style change clears a running dead window (code 7)
      dead_code = 3'd7;
      go_idle();
      qpulse_in = 1'b1;
      seen = 1'b0;
      for (int i = 1; i <= 18; i++) begin
         @(negedge clk);
         if (i == 16) seen = out_bit;
         if (i == 5)  qpulse_in = 1'b0;
         if (i == 8)  tot_sel = 1'b1;
         if (i == 10) tot_sel = 1'b0;
         if (i == 12) qpulse_in = 1'b1;
         if (i == 15) qpulse_in = 1'b0;
      end
      check("R8 window cleared by style change", seen, 1'b1);

      // R8: mode change mid-pulse takes effect at the next edge
      go_idle();
      qpulse_in = 1'b1;
      tick(6);
      check("R8 output high mid-pulse", out_bit, 1'b1);
      chan_mode = 2'b10;
      tick(1);
      check("R8 forced low applied next edge", out_bit, 1'b0);
      chan_mode = 2'b00;
      tick(3);
      check("R8 pulse not resumed after override", out_bit, 1'b0);
      qpulse_in = 1'b0;

      // R3: off ignores charge activity
      go_idle();
      chan_mode = 2'b11;
      qpulse_in = 1'b1;
      tick(6);
      check("R3 off with charge pulse", out_bit, 1'b0);

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule